// File: doc/BRIEF.md
# ECC chunk status accumulator

After a page has been read through an error-correcting decoder, the decoder leaves one status byte per data chunk in an auxiliary buffer, just after a small metadata area. This block walks those status bytes and sums up the page's error picture: how many bits were corrected in total and how many chunks could not be corrected at all. A controller pulses `start_i` with the page data size in bytes. The block derives the chunk count and the start address of the status bytes itself, reads one byte per cycle through a synchronous read port, and raises `done_o` for one cycle once the totals are final.

Each status byte is one of three reserved codes or a count. 0x00 marks a clean chunk, 0xFF an erased chunk, and 0xFE an uncorrectable chunk. Any other value is the number of bitflips the decoder repaired in that chunk. The corrected total saturates at its maximum instead of wrapping, so a page with very many flips never looks cleaner than it is.

The control is a four-state machine. `S_IDLE` waits for a start. `S_ISSUE` sends one read address per cycle. `S_DRAIN` takes in the final byte, which arrives one cycle after its address. `S_FINISH` is the single cycle in which `done_o` is high. The transitions are: IDLE to ISSUE on a start with at least one chunk; IDLE to FINISH on a start with zero chunks; ISSUE to DRAIN once the last address has gone out; DRAIN to FINISH; FINISH to IDLE.

Top module: `ecs_status_scan`

## Requirements
- R1: The chunk count is the page data size divided by 512, rounded down. Exactly that many status bytes are read, and any remainder below 512 bytes is ignored.
- R2: Status bytes are read at consecutive byte addresses starting at 12, which is the 10-byte metadata size rounded up to a multiple of 4. One address is issued per cycle with `rd_en_o` high, and `rd_data_i` returns that byte one cycle later.
- R3: Status codes 0x00 (clean) and 0xFF (erased) change neither total.
- R4: Status code 0xFE (uncorrectable) increments `failed_o` by one.
- R5: Any other status value (0x01 to 0xFD) is added to `corrected_o`.
- R6: `corrected_o` is 16 bits wide and holds at 0xFFFF rather than wrapping.
- R7: An accepted start clears both totals. The totals then hold their final values after done until the next accepted start.
- R8: `done_o` is a one-cycle pulse that appears N+2 cycles after the start cycle for N chunks, and 1 cycle after it when N is 0. No read is issued when N is 0.
- R9: A start pulse that arrives while a scan is in progress is ignored. It changes neither the result nor the timing.
- R10: After reset, `done_o` and `rd_en_o` are low and both totals are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| page_bytes_i | input | 18 | Page data size in bytes, sampled at start |
| rd_en_o | output | 1 | Read strobe into the auxiliary buffer |
| rd_addr_o | output | 10 | Byte address of the status byte being read |
| rd_data_i | input | 8 | Byte returned one cycle after the strobe |
| done_o | output | 1 | One-cycle completion pulse |
| corrected_o | output | 16 | Saturating total of corrected bits |
| failed_o | output | 9 | Count of uncorrectable chunks |

## Verification
The assertions assume that the buffer returns the addressed byte exactly one cycle after the strobe, and that `start_i` is a single-cycle pulse. Under those assumptions, the totals can only grow between accepted starts. The stimulus keeps within these assumptions: it models the buffer as a registered byte array, drives every start as a one-cycle pulse, and places the deliberate mid-scan start only while the block is busy. Page sizes stay small enough that every status address fits the 10-bit port, with one long all-0xFD page used to force saturation.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ISSUE  = 2'd1,
        S_DRAIN  = 2'd2,
        S_FINISH = 2'd3
    } scan_state_t;

    localparam logic [7:0] CODE_CLEAN  = 8'h00;
    localparam logic [7:0] CODE_ERASED = 8'hFF;
    localparam logic [7:0] CODE_UNCORR = 8'hFE;

    function automatic int word_align(input int bytes);
        return ((bytes + 3) / 4) * 4;
    endfunction

endpackage

// File: rtl/ecs_addr_gen.sv
module ecs_addr_gen #(
    parameter int CNT_W       = 9,
    parameter int ADDR_W      = 10,
    parameter int STATUS_BASE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  chunks_i,
    input  logic              step_i,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            idx_q   <= '0;
        end else if (load_i) begin
            count_q <= chunks_i;
            idx_q   <= '0;
        end else if (step_i) begin
            idx_q   <= idx_q + 1'b1;
        end
    end

    assign last_o = (idx_q == count_q - 1'b1);
    assign addr_o = ADDR_W'(STATUS_BASE) + ADDR_W'(idx_q);

endmodule

// File: rtl/ecs_decode.sv
module ecs_decode
    import ecs_pkg::*;
(
    input  logic [7:0] code_i,
    output logic [7:0] add_o,
    output logic       bad_o
);
    always_comb begin
        add_o = code_i;
        bad_o = 1'b0;
        unique case (code_i)
            CODE_CLEAN:  add_o = 8'd0;
            CODE_ERASED: add_o = 8'd0;
            CODE_UNCORR: begin
                add_o = 8'd0;
                bad_o = 1'b1;
            end
            default:     add_o = code_i;
        endcase
    end

endmodule

// File: rtl/ecs_accum.sv
module ecs_accum #(
    parameter int CORR_W = 16,
    parameter int FAIL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [7:0]        add_i,
    input  logic              bad_i,
    output logic [CORR_W-1:0] corr_o,
    output logic [FAIL_W-1:0] fail_o
);
    logic [CORR_W:0] sum;

    assign sum = {1'b0, corr_o} + (CORR_W+1)'(add_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            corr_o <= '0;
            fail_o <= '0;
        end else if (clr_i) begin
            corr_o <= '0;
            fail_o <= '0;
        end else if (en_i) begin
            corr_o <= sum[CORR_W] ? '1 : sum[CORR_W-1:0];
            fail_o <= fail_o + FAIL_W'(bad_i);
        end
    end

endmodule

// File: rtl/ecs_status_scan.sv
module ecs_status_scan
    import ecs_pkg::*;
#(
    parameter int PAGE_W      = 18,
    parameter int CHUNK_BYTES = 512,
    parameter int META_BYTES  = 10,
    parameter int ADDR_W      = 10,
    parameter int CORR_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] page_bytes_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              done_o,
    output logic [CORR_W-1:0] corrected_o,
    output logic [PAGE_W-$clog2(CHUNK_BYTES)-1:0] failed_o
);
    localparam int CHUNK_SHIFT = $clog2(CHUNK_BYTES);
    localparam int CNT_W       = PAGE_W - CHUNK_SHIFT;
    localparam int FAIL_W      = CNT_W;
    localparam int STATUS_BASE = word_align(META_BYTES);

    scan_state_t      state_q, state_d;
    logic [CNT_W-1:0] chunks;
    logic             accept, last_addr, vld_q;
    logic [7:0]       add_val;
    logic             add_bad;

    assign chunks = page_bytes_i[PAGE_W-1:CHUNK_SHIFT];
    assign accept = (state_q == S_IDLE) && start_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = (chunks == '0) ? S_FINISH : S_ISSUE;
            S_ISSUE:  if (last_addr) state_d = S_DRAIN;
            S_DRAIN:  state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            vld_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            vld_q   <= rd_en_o;
        end
    end

    always_comb begin
        rd_en_o = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_ISSUE:  rd_en_o = 1'b1;
            S_DRAIN:  ;
            S_FINISH: done_o = 1'b1;
        endcase
    end

    ecs_addr_gen #(
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W),
        .STATUS_BASE(STATUS_BASE)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .chunks_i(chunks),
        .step_i  (rd_en_o),
        .last_o  (last_addr),
        .addr_o  (rd_addr_o)
    );

    ecs_decode u_dec (
        .code_i(rd_data_i),
        .add_o (add_val),
        .bad_o (add_bad)
    );

    ecs_accum #(
        .CORR_W(CORR_W),
        .FAIL_W(FAIL_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (accept),
        .en_i  (vld_q),
        .add_i (add_val),
        .bad_i (add_bad),
        .corr_o(corrected_o),
        .fail_o(failed_o)
    );

endmodule

// File: rtl/ecs_checker.sv
module ecs_checker #(
    parameter int ADDR_W      = 10,
    parameter int CORR_W      = 16,
    parameter int FAIL_W      = 9,
    parameter int STATUS_BASE = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_en_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              done_o,
    input logic [CORR_W-1:0] corrected_o,
    input logic [FAIL_W-1:0] failed_o
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_en_o); // R8

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && !$past(rd_en_o)) |-> rd_addr_o == ADDR_W'(STATUS_BASE)); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> rd_addr_o == $past(rd_addr_o) + 1'b1); // R2

    AST_CORR_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_i) |-> corrected_o >= $past(corrected_o)); // R5

    AST_FAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_i) |-> (failed_o == $past(failed_o) || failed_o == $past(failed_o) + 1'b1)); // R4

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(corrected_o) == '1 && !$past(start_i)) |-> corrected_o == '1); // R6

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(corrected_o) && $stable(failed_o))); // R7

endmodule

bind ecs_status_scan ecs_checker #(
    .ADDR_W     (ADDR_W),
    .CORR_W     (CORR_W),
    .FAIL_W     (FAIL_W),
    .STATUS_BASE(STATUS_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .done_o     (done_o),
    .corrected_o(corrected_o),
    .failed_o   (failed_o)
);

// File: tb/ecs_status_scan_bench.sv
module ecs_status_scan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [17:0] page_bytes_i = '0;
    logic        rd_en_o;
    logic [9:0]  rd_addr_o;
    logic [7:0]  rd_data_i;
    logic        done_o;
    logic [15:0] corrected_o;
    logic [8:0]  failed_o;

    logic [7:0] mem [0:1023];
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

    ecs_status_scan u_ecs_status_scan (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_bytes_i(page_bytes_i),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .done_o(done_o), .corrected_o(corrected_o), .failed_o(failed_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_corr(input int n);
        int s = 0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] c = mem[BASE+i];
            if (c != 8'h00 && c != 8'hFF && c != 8'hFE) s += c;
        end
        return (s > 65535) ? 65535 : s;
    endfunction

    function automatic int exp_fail(input int n);
        int f = 0;
        for (int i = 0; i < n; i++) if (mem[BASE+i] == 8'hFE) f++;
        return f;
    endfunction

    function automatic logic [7:0] rand_code();
        int k = $urandom_range(0, 5);
        case (k)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'hFE;
            default: return 8'($urandom_range(1, 253));
        endcase
    endfunction

    // One scan; mid > 0 pulses start again mid-scan (R9)
    task automatic run(input int bytes, input int mid, input string tag);
        int n = bytes / 512;
        int lat = 0;
        int reads = 0;
        int addr_err = 0;
        int ec = exp_corr(n);
        int ef = exp_fail(n);
        @(negedge clk);
        page_bytes_i = 18'(bytes);
        start_i = 1'b1;
        forever begin
            @(negedge clk);
            lat++;
            start_i = (mid > 0 && lat == mid) ? 1'b1 : 1'b0;
            if (mid > 0 && lat == mid) page_bytes_i = '0;
            if (rd_en_o) begin
                if (int'(rd_addr_o) != BASE + reads) addr_err++;
                reads++;
            end
            if (done_o || lat > n + 20) break;
        end
        start_i = 1'b0;
        chk(lat == ((n == 0) ? 1 : n + 2), "R8", {tag, " done latency"}, lat, (n == 0) ? 1 : n + 2);
        chk(reads == n, "R1", {tag, " read count"}, reads, n);
        chk(addr_err == 0, "R2", {tag, " address order"}, addr_err, 0);
        chk(int'(corrected_o) == ec, "R5", {tag, " corrected"}, int'(corrected_o), ec);
        chk(int'(failed_o) == ef, "R4", {tag, " failed"}, int'(failed_o), ef);
        @(negedge clk);
        chk(!done_o, "R8", {tag, " done single"}, int'(done_o), 0);
        chk(int'(corrected_o) == ec && int'(failed_o) == ef, "R7", {tag, " hold"},
            int'(corrected_o), ec);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!done_o && !rd_en_o && corrected_o == 0 && failed_o == 0, "R10",
            "reset state", int'(corrected_o), 0);
        rst_n = 1'b1;

        // R3 R4 R5: mixed codes
        mem[BASE+0] = 8'h00; mem[BASE+1] = 8'hFF; mem[BASE+2] = 8'hFE; mem[BASE+3] = 8'h05;
        run(2048, 0, "mix");
        chk(corrected_o == 16'd5 && failed_o == 9'd1, "R3", "reserved codes", int'(corrected_o), 5);

        // R5 boundary values 0x01 and 0xFD
        mem[BASE+0] = 8'h01; mem[BASE+1] = 8'hFD;
        run(1024, 0, "edge");
        chk(corrected_o == 16'd254, "R5", "0x01+0xFD", int'(corrected_o), 254);

        // R1 remainder ignored; R7 cleared before
        run(2047, 0, "floor");
        run(511, 0, "sub-chunk");
        chk(corrected_o == 0 && failed_o == 0, "R7", "cleared by start", int'(corrected_o), 0);
        run(0, 0, "empty");

        // R4 all uncorrectable
        for (int i = 0; i < 20; i++) mem[BASE+i] = 8'hFE;
        run(20 * 512, 0, "allbad");

        // R6 saturation
        for (int i = 0; i < 300; i++) mem[BASE+i] = 8'hFD;
        run(300 * 512, 0, "sat");
        chk(corrected_o == 16'hFFFF, "R6", "saturated", int'(corrected_o), 65535);

        // R9 start during a scan
        for (int i = 0; i < 8; i++) mem[BASE+i] = rand_code();
        run(8 * 512, 3, "restart");

        // Random pages
        for (int r = 0; r < 20; r++) begin
            int n = $urandom_range(1, 40);
            for (int i = 0; i < n; i++) mem[BASE+i] = rand_code();
            run(n * 512 + $urandom_range(0, 511), 0, "random");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule